// File: doc/BRIEF.md
# Reset and Clock Startup Sequencer

This block sits at the centre of a small microcontroller and decides when the processor and its peripherals may run. It merges seven reset causes into one internal reset. It holds the processor and peripheral clock enables low through the power-up timeout and through the recovery delay after stop mode. While it holds a reset of its own making, it pulls the shared reset pin low through an open-drain enable. It also produces a bus strobe at one quarter of the rate of a selectable reference, which is either the oscillator (every cycle) or a strobe from the PLL.

All timing runs on the oscillator clock. One counter times three waits: the power-up hold, the hold after an internal fault reset, and the stop-exit delay. An external pin reset freezes this counter instead of clearing it, so a pin pulse during stop recovery lengthens the recovery and does not restart it. The pin is first passed through a two-flop synchronizer, and its low time is then measured before it can be logged as a reset cause. Each accepted cause sets a bit in a status byte. Software reads that byte through a read strobe, and the read clears it. The block also presents the fetch address of the reset vector, which depends on the monitor-mode input.

Top module: `rstclk_seq`

## Requirements
- R1: While `rst_i` is high and for exactly 4096 cycles after the last cycle in which it was sampled high, `irst_o` and `rst_pin_drive_o` are 1 and both clock enables are 0. After that `cpu_clk_en_o` and `per_clk_en_o` become 1.
- R2: A pulse on `lvi_i` restarts the same 4096-cycle hold with pin drive, counted from the cycle in which it was sampled, and sets status bit 6.
- R3: A pulse on `cop_i`, `ill_op_i`, `ill_addr_i` or `mon_rst_i` (outside the power-up hold) clears the counter, asserts `irst_o` and `rst_pin_drive_o`, and keeps the clocks off for exactly 64 cycles. The pulse sets status bit 2, 3, 4 or 5 respectively.
- R4: A `stop_req_i` pulse turns both clock enables off. A later `wake_i` pulse turns them back on exactly 32 cycles after the wake cycle if `stop_short_i` is 1, and 4096 cycles after it if `stop_short_i` is 0.
- R5: A `wait_req_i` pulse turns off only `cpu_clk_en_o`. A `wake_i` pulse turns it back on.
- R6: While the synchronized pin is low and the block is not driving it, `irst_o` is 1, both clock enables are 0 and `rst_pin_drive_o` is 0. A pin pulse of L cycles during stop recovery leaves the counter unchanged, so the clocks return exactly delay+L cycles after the wake cycle.
- R7: Status bit 1 is set only if the pin stays low for at least 67 cycles and the block is not in the power-up/low-voltage hold. A 66-cycle pulse does not set it.
- R8: `stat_data_o` shows the status byte as {0, lvi, mon, ill_addr, ill_op, cop, pin, por}. A cycle with `stat_rd_i` high clears it, and later causes OR their bits in. `rst_i` leaves only bit 0 set.
- R9: `bus_tick_o` pulses once per four source strobes. The source strobe is every cycle when `clk_sel_i`=0 and `pll_tick_i` when `clk_sel_i`=1. The bus strobe never pulses while `per_clk_en_o` is 0.
- R10: `vector_o` is 16'hFFFE when `mon_mode_i`=0 and 16'hFEFE when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Power-on reset, synchronous, active high |
| clk_sel_i | input | 1 | Bus source: 0 oscillator, 1 PLL strobe |
| pll_tick_i | input | 1 | PLL clock strobe in the oscillator domain |
| lvi_i | input | 1 | Low-voltage event |
| cop_i | input | 1 | Watchdog timeout event |
| ill_op_i | input | 1 | Illegal opcode event |
| ill_addr_i | input | 1 | Illegal address event |
| mon_rst_i | input | 1 | Forced monitor-entry reset event |
| rst_pin_n_i | input | 1 | Asynchronous reset pin level |
| stop_req_i | input | 1 | Enter stop mode |
| wait_req_i | input | 1 | Enter wait mode |
| wake_i | input | 1 | Wake-up interrupt |
| stop_short_i | input | 1 | Short stop-exit delay select |
| mon_mode_i | input | 1 | Monitor mode active |
| stat_rd_i | input | 1 | Status read strobe (clears status) |
| stat_data_o | output | 8 | Reset status byte |
| irst_o | output | 1 | Internal reset |
| rst_pin_drive_o | output | 1 | Open-drain pull-down enable for the reset pin |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| bus_tick_o | output | 1 | Bus clock strobe |
| vector_o | output | 16 | Reset vector fetch address |

## Verification
The assertions assume that event inputs are single-cycle pulses and that the pin input reflects the block's own pull-down, as a wired open-drain net does. The bench keeps to this by forming the pin as its external level ANDed with the inverse of `rst_pin_drive_o`. The bench also starts pin pulses during stop recovery well inside the delay window, so that the pulse cannot coincide with the last counting cycle.

// File: rtl/rstclk_seq_pkg.sv
package rstclk_seq_pkg;

    typedef enum logic [2:0] {
        SQ_POR_HOLD,
        SQ_INT_HOLD,
        SQ_PIN,
        SQ_RUN,
        SQ_WAIT,
        SQ_STOP,
        SQ_STOP_EXIT
    } sq_state_e;

    typedef struct packed {
        logic lvi;
        logic mon;
        logic ill_addr;
        logic ill_op;
        logic cop;
        logic pin;
        logic por;
    } rst_cause_t;

    typedef struct packed {
        logic cpu;
        logic per;
    } clk_en_t;

    localparam logic [15:0] VEC_NORMAL = 16'hFFFE;
    localparam logic [15:0] VEC_MON    = 16'hFEFE;

    function automatic clk_en_t clocks_for(sq_state_e st);
        clk_en_t e;
        e.cpu = (st == SQ_RUN);
        e.per = (st == SQ_RUN) || (st == SQ_WAIT);
        return e;
    endfunction

    function automatic logic in_reset(sq_state_e st);
        return (st == SQ_POR_HOLD) || (st == SQ_INT_HOLD) || (st == SQ_PIN);
    endfunction

    function automatic logic drives_pin(sq_state_e st);
        return (st == SQ_POR_HOLD) || (st == SQ_INT_HOLD);
    endfunction

    function automatic logic [15:0] vector_for(logic mon);
        return mon ? VEC_MON : VEC_NORMAL;
    endfunction

endpackage

// File: rtl/rstclk_seq_pin.sv
module rstclk_seq_pin #(
    parameter int PIN_MIN = 67
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_async,
    input  logic drive,
    input  logic allow,
    output logic pin_low_o,
    output logic flag_set_o
);
    localparam int PLW = $clog2(PIN_MIN + 1);

    logic sync1_q, sync2_q;
    logic drv_d1_q, drv_d2_q;
    logic [PLW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q  <= 1'b1;
            sync2_q  <= 1'b1;
            drv_d1_q <= 1'b0;
            drv_d2_q <= 1'b0;
        end else begin
            sync1_q  <= pin_n_async;
            sync2_q  <= sync1_q;
            drv_d1_q <= drive;
            drv_d2_q <= drv_d1_q;
        end
    end

    // Own pull-down is still visible through the synchronizer for two cycles
    assign pin_low_o = ~sync2_q & ~drive & ~drv_d1_q & ~drv_d2_q;

    always_ff @(posedge clk) begin
        if (rst || !pin_low_o) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != PLW'(PIN_MIN)) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign flag_set_o = pin_low_o && allow && (low_cnt_q == PLW'(PIN_MIN - 1));

endmodule

// File: rtl/rstclk_seq_fsm.sv
module rstclk_seq_fsm
    import rstclk_seq_pkg::*;
#(
    parameter int POR_CYCLES = 4096,
    parameter int INT_CYCLES = 64,
    parameter int STOP_LONG  = 4096,
    parameter int STOP_SHORT = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lvi,
    input  logic      int_evt,
    input  logic      pin_low,
    input  logic      stop_req,
    input  logic      wait_req,
    input  logic      wake,
    input  logic      stop_short,
    output sq_state_e state_o
);
    localparam int MAXC  = (POR_CYCLES > STOP_LONG) ?
                           ((POR_CYCLES > INT_CYCLES) ? POR_CYCLES : INT_CYCLES) :
                           ((STOP_LONG > INT_CYCLES) ? STOP_LONG : INT_CYCLES);
    localparam int CNT_W = $clog2(MAXC + 1);

    sq_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_q, lim_q;
    logic             ret_exit_q;
    logic             clr;
    logic             counting;

    always_comb begin
        state_n = state_q;
        clr     = 1'b0;
        if (lvi) begin
            state_n = SQ_POR_HOLD;
            clr     = 1'b1;
        end else if (int_evt && state_q != SQ_POR_HOLD) begin
            state_n = SQ_INT_HOLD;
            clr     = 1'b1;
        end else begin
            case (state_q)
                SQ_POR_HOLD:
                    if (cnt_q >= CNT_W'(POR_CYCLES - 1)) state_n = SQ_RUN;
                SQ_INT_HOLD:
                    if (cnt_q >= CNT_W'(INT_CYCLES - 1)) state_n = SQ_RUN;
                SQ_PIN:
                    if (!pin_low) state_n = ret_exit_q ? SQ_STOP_EXIT : SQ_RUN;
                SQ_RUN:
                    if (pin_low)       state_n = SQ_PIN;
                    else if (stop_req) state_n = SQ_STOP;
                    else if (wait_req) state_n = SQ_WAIT;
                SQ_WAIT:
                    if (pin_low)   state_n = SQ_PIN;
                    else if (wake) state_n = SQ_RUN;
                SQ_STOP:
                    if (pin_low) state_n = SQ_PIN;
                    else if (wake) begin
                        state_n = SQ_STOP_EXIT;
                        clr     = 1'b1;
                    end
                SQ_STOP_EXIT:
                    if (pin_low)                state_n = SQ_PIN;
                    else if (cnt_q >= lim_q - 1'b1) state_n = SQ_RUN;
                default: state_n = SQ_POR_HOLD;
            endcase
        end
    end

    assign counting = (state_q == SQ_POR_HOLD) || (state_q == SQ_INT_HOLD) ||
                      (state_q == SQ_STOP_EXIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_POR_HOLD;
            cnt_q      <= '0;
            lim_q      <= CNT_W'(STOP_LONG);
            ret_exit_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (clr)           cnt_q <= '0;
            else if (counting) cnt_q <= cnt_q + 1'b1;
            if (state_q == SQ_STOP && state_n == SQ_STOP_EXIT)
                lim_q <= stop_short ? CNT_W'(STOP_SHORT) : CNT_W'(STOP_LONG);
            if (state_n == SQ_PIN && state_q != SQ_PIN)
                ret_exit_q <= (state_q == SQ_STOP_EXIT);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rstclk_seq_busdiv.sv
module rstclk_seq_busdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_pll,
    input  logic pll_tick,
    input  logic run,
    output logic bus_tick_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;
    logic          tick_q;
    logic          src;

    assign src = sel_pll ? pll_tick : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q  <= '0;
            tick_q <= 1'b0;
        end else if (src) begin
            div_q  <= (div_q == DW'(DIV - 1)) ? '0 : div_q + 1'b1;
            tick_q <= (div_q == DW'(DIV - 1));
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign bus_tick_o = tick_q & run;

endmodule

// File: rtl/rstclk_seq_status.sv
module rstclk_seq_status
    import rstclk_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rst_cause_t set,
    input  logic       rd,
    output logic [7:0] data_o
);
    rst_cause_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.por <= 1'b1;
        end else begin
            q <= (rd ? rst_cause_t'('0) : q) | set;
        end
    end

    assign data_o = {1'b0, q};

endmodule

// File: rtl/rstclk_seq.sv
module rstclk_seq
    import rstclk_seq_pkg::*;
#(
    parameter int POR_CYCLES = 4096,
    parameter int INT_CYCLES = 64,
    parameter int STOP_LONG  = 4096,
    parameter int STOP_SHORT = 32,
    parameter int PIN_MIN    = 67,
    parameter int BUS_DIV    = 4
) (
    input  logic        clk_osc_i,
    input  logic        rst_i,
    input  logic        clk_sel_i,
    input  logic        pll_tick_i,
    input  logic        lvi_i,
    input  logic        cop_i,
    input  logic        ill_op_i,
    input  logic        ill_addr_i,
    input  logic        mon_rst_i,
    input  logic        rst_pin_n_i,
    input  logic        stop_req_i,
    input  logic        wait_req_i,
    input  logic        wake_i,
    input  logic        stop_short_i,
    input  logic        mon_mode_i,
    input  logic        stat_rd_i,
    output logic [7:0]  stat_data_o,
    output logic        irst_o,
    output logic        rst_pin_drive_o,
    output logic        cpu_clk_en_o,
    output logic        per_clk_en_o,
    output logic        bus_tick_o,
    output logic [15:0] vector_o
);
    sq_state_e  state;
    clk_en_t    en;
    rst_cause_t cause_set;
    logic       pin_low, pin_flag, accept, int_evt;

    assign int_evt = cop_i | ill_op_i | ill_addr_i | mon_rst_i;

    rstclk_seq_fsm #(
        .POR_CYCLES (POR_CYCLES),
        .INT_CYCLES (INT_CYCLES),
        .STOP_LONG  (STOP_LONG),
        .STOP_SHORT (STOP_SHORT)
    ) fsm_i (
        .clk        (clk_osc_i),
        .rst        (rst_i),
        .lvi        (lvi_i),
        .int_evt    (int_evt),
        .pin_low    (pin_low),
        .stop_req   (stop_req_i),
        .wait_req   (wait_req_i),
        .wake       (wake_i),
        .stop_short (stop_short_i),
        .state_o    (state)
    );

    rstclk_seq_pin #(.PIN_MIN(PIN_MIN)) pin_i (
        .clk         (clk_osc_i),
        .rst         (rst_i),
        .pin_n_async (rst_pin_n_i),
        .drive       (rst_pin_drive_o),
        .allow       (state != SQ_POR_HOLD),
        .pin_low_o   (pin_low),
        .flag_set_o  (pin_flag)
    );

    assign en              = clocks_for(state);
    assign cpu_clk_en_o    = en.cpu;
    assign per_clk_en_o    = en.per;
    assign irst_o          = in_reset(state);
    assign rst_pin_drive_o = drives_pin(state);

    rstclk_seq_busdiv #(.DIV(BUS_DIV)) div_i (
        .clk        (clk_osc_i),
        .rst        (rst_i),
        .sel_pll    (clk_sel_i),
        .pll_tick   (pll_tick_i),
        .run        (en.per),
        .bus_tick_o (bus_tick_o)
    );

    assign accept = (state != SQ_POR_HOLD) && !lvi_i;

    always_comb begin
        cause_set          = '0;
        cause_set.lvi      = lvi_i;
        cause_set.pin      = pin_flag;
        cause_set.cop      = cop_i & accept;
        cause_set.ill_op   = ill_op_i & accept;
        cause_set.ill_addr = ill_addr_i & accept;
        cause_set.mon      = mon_rst_i & accept;
    end

    rstclk_seq_status stat_i (
        .clk    (clk_osc_i),
        .rst    (rst_i),
        .set    (cause_set),
        .rd     (stat_rd_i),
        .data_o (stat_data_o)
    );

    assign vector_o = vector_for(mon_mode_i);

endmodule

// File: rtl/rstclk_seq_chk.sv
module rstclk_seq_chk (
    input logic clk_osc_i,
    input logic rst_i,
    input logic lvi_i,
    input logic irst_o,
    input logic rst_pin_drive_o,
    input logic cpu_clk_en_o,
    input logic per_clk_en_o,
    input logic bus_tick_o
);
    // R1
    irst_gate_chk: assert property (@(posedge clk_osc_i) disable iff (rst_i)
        irst_o |-> (!cpu_clk_en_o && !per_clk_en_o));

    // R1
    por_entry_chk: assert property (@(posedge clk_osc_i) disable iff (rst_i)
        $past(rst_i) |-> (irst_o && rst_pin_drive_o));

    // R2
    lvi_hold_chk: assert property (@(posedge clk_osc_i) disable iff (rst_i)
        lvi_i |=> (irst_o && rst_pin_drive_o));

    // R3
    drive_irst_chk: assert property (@(posedge clk_osc_i) disable iff (rst_i)
        rst_pin_drive_o |-> irst_o);

    // R5
    cpu_per_chk: assert property (@(posedge clk_osc_i) disable iff (rst_i)
        cpu_clk_en_o |-> per_clk_en_o);

    // R9
    bus_gate_chk: assert property (@(posedge clk_osc_i) disable iff (rst_i)
        bus_tick_o |-> per_clk_en_o);

    // R9
    bus_space_chk: assert property (@(posedge clk_osc_i) disable iff (rst_i)
        bus_tick_o |=> !bus_tick_o);

endmodule

bind rstclk_seq rstclk_seq_chk chk_i (
    .clk_osc_i       (clk_osc_i),
    .rst_i           (rst_i),
    .lvi_i           (lvi_i),
    .irst_o          (irst_o),
    .rst_pin_drive_o (rst_pin_drive_o),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .per_clk_en_o    (per_clk_en_o),
    .bus_tick_o      (bus_tick_o)
);

// File: tb/rstclk_seq_tb_top.sv
module rstclk_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic clk_sel_i = 1'b0, pll_tick_i = 1'b0;
    logic lvi_i = 1'b0, cop_i = 1'b0, ill_op_i = 1'b0, ill_addr_i = 1'b0, mon_rst_i = 1'b0;
    logic ext_pin_n = 1'b1;
    logic stop_req_i = 1'b0, wait_req_i = 1'b0, wake_i = 1'b0, stop_short_i = 1'b0;
    logic mon_mode_i = 1'b0, stat_rd_i = 1'b0;
    logic [7:0]  stat_data_o;
    logic        irst_o, rst_pin_drive_o, cpu_clk_en_o, per_clk_en_o, bus_tick_o;
    logic [15:0] vector_o;
    logic        rst_pin_n;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rst_pin_n = ext_pin_n & ~rst_pin_drive_o;

    rstclk_seq dut_i (
        .clk_osc_i       (clk),
        .rst_i           (rst_i),
        .clk_sel_i       (clk_sel_i),
        .pll_tick_i      (pll_tick_i),
        .lvi_i           (lvi_i),
        .cop_i           (cop_i),
        .ill_op_i        (ill_op_i),
        .ill_addr_i      (ill_addr_i),
        .mon_rst_i       (mon_rst_i),
        .rst_pin_n_i     (rst_pin_n),
        .stop_req_i      (stop_req_i),
        .wait_req_i      (wait_req_i),
        .wake_i          (wake_i),
        .stop_short_i    (stop_short_i),
        .mon_mode_i      (mon_mode_i),
        .stat_rd_i       (stat_rd_i),
        .stat_data_o     (stat_data_o),
        .irst_o          (irst_o),
        .rst_pin_drive_o (rst_pin_drive_o),
        .cpu_clk_en_o    (cpu_clk_en_o),
        .per_clk_en_o    (per_clk_en_o),
        .bus_tick_o      (bus_tick_o),
        .vector_o        (vector_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // counts clock edges from the current negedge until the peripheral enable is seen
    task automatic cycles_to_on(output int n);
        n = 0;
        while (n < 10000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (per_clk_en_o) break;
        end
    endtask

    task automatic read_stat(output logic [7:0] v);
        @(negedge clk);
        stat_rd_i = 1'b1;
        #1 v = stat_data_o;
        @(negedge clk);
        stat_rd_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] st;
        int acc;

        repeat (3) @(negedge clk);
        chk("R1 irst in reset", irst_o, 1);
        chk("R1 drive in reset", rst_pin_drive_o, 1);
        chk("R1 clocks off in reset", {cpu_clk_en_o, per_clk_en_o}, 0);

        rst_i = 1'b0;
        cycles_to_on(n);
        chk("R1 power-up hold length", n, 4096);
        chk("R1 irst released", {irst_o, rst_pin_drive_o, cpu_clk_en_o}, 3'b001);
        read_stat(st);
        chk("R8 status after power-on", st, 8'h01);
        read_stat(st);
        chk("R8 read clears status", st, 8'h00);

        mon_mode_i = 1'b0; #1;
        chk("R10 normal vector", vector_o, 16'hFFFE);
        mon_mode_i = 1'b1; #1;
        chk("R10 monitor vector", vector_o, 16'hFEFE);
        mon_mode_i = 1'b0;

        // R9 oscillator source: 40 strobes -> 10 bus ticks
        acc = 0;
        clk_sel_i = 1'b0;
        for (int i = 0; i <= 40; i++) begin
            @(negedge clk);
            if (i > 0) acc += int'(bus_tick_o);
        end
        chk("R9 oscillator divide", acc, 10);

        // R9 PLL strobe every third cycle: 20 strobes -> 5 bus ticks
        acc = 0;
        clk_sel_i = 1'b1;
        for (int i = 0; i <= 60; i++) begin
            @(negedge clk);
            if (i > 0) acc += int'(bus_tick_o);
            pll_tick_i = (i < 60) && (i % 3 == 0);
        end
        chk("R9 PLL divide", acc, 5);
        clk_sel_i = 1'b0;

        // R5 wait mode
        @(negedge clk) wait_req_i = 1'b1;
        @(negedge clk) wait_req_i = 1'b0;
        chk("R5 wait gates cpu only", {cpu_clk_en_o, per_clk_en_o}, 2'b01);
        @(negedge clk) wake_i = 1'b1;
        @(negedge clk) wake_i = 1'b0;
        chk("R5 wake restores cpu", {cpu_clk_en_o, per_clk_en_o}, 2'b11);

        // R4 stop with short and long delay
        for (int s = 1; s >= 0; s--) begin
            @(negedge clk) stop_req_i = 1'b1;
            @(negedge clk) stop_req_i = 1'b0;
            chk("R4 stop gates clocks", {cpu_clk_en_o, per_clk_en_o, irst_o}, 0);
            acc = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                acc += int'(bus_tick_o);
            end
            chk("R9 no bus tick in stop", acc, 0);
            stop_short_i = s[0];
            @(negedge clk) wake_i = 1'b1;
            @(negedge clk) wake_i = 1'b0;
            cycles_to_on(n);
            chk("R4 stop exit delay", n, (s == 1) ? 32 : 4096);
        end
        read_stat(st);
        chk("R4 no status from stop", st, 0);

        // R3 sweep the internal fault sources
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cop_i = (k == 0); ill_op_i = (k == 1); ill_addr_i = (k == 2); mon_rst_i = (k == 3);
            @(negedge clk);
            {cop_i, ill_op_i, ill_addr_i, mon_rst_i} = 4'b0;
            chk("R3 fault drives pin", {irst_o, rst_pin_drive_o, per_clk_en_o}, 3'b110);
            cycles_to_on(n);
            chk("R3 fault hold length", n, 64);
            read_stat(st);
            chk("R3 fault status bit", st, 1 << (k + 2));
        end

        // R8 causes accumulate
        @(negedge clk) cop_i = 1'b1;
        @(negedge clk) cop_i = 1'b0;
        cycles_to_on(n);
        @(negedge clk) ill_op_i = 1'b1;
        @(negedge clk) ill_op_i = 1'b0;
        cycles_to_on(n);
        read_stat(st);
        chk("R8 status bits OR together", st, 8'h0C);

        // R2 low-voltage event
        @(negedge clk) lvi_i = 1'b1;
        @(negedge clk) lvi_i = 1'b0;
        cycles_to_on(n);
        chk("R2 low-voltage hold length", n, 4096);
        read_stat(st);
        chk("R2 low-voltage status bit", st, 8'h40);

        // R7 and R6 pin pulses of 66 and 67 cycles
        for (int len = 66; len <= 67; len++) begin
            @(negedge clk) ext_pin_n = 1'b0;
            for (int i = 1; i < len; i++) begin
                @(negedge clk);
                if (i == 10)
                    chk("R6 pin reset outputs", {irst_o, rst_pin_drive_o, per_clk_en_o}, 3'b100);
            end
            @(negedge clk) ext_pin_n = 1'b1;
            repeat (4) @(negedge clk);
            chk("R6 clocks back after pin", {irst_o, cpu_clk_en_o}, 2'b01);
            read_stat(st);
            chk("R7 pin flag vs low time", st, (len >= 67) ? 8'h02 : 8'h00);
        end

        // R6 pin pulse during stop recovery extends delay without restarting it
        stop_short_i = 1'b1;
        @(negedge clk) stop_req_i = 1'b1;
        @(negedge clk) stop_req_i = 1'b0;
        @(negedge clk) wake_i = 1'b1;
        @(negedge clk) wake_i = 1'b0;
        fork
            cycles_to_on(n);
            begin
                repeat (5) @(negedge clk);
                ext_pin_n = 1'b0;
                repeat (20) @(negedge clk);
                ext_pin_n = 1'b1;
            end
        join
        chk("R6 stop delay plus pin time", n, 32 + 20);
        read_stat(st);
        chk("R7 short pin pulse not logged", st, 0);

        // R7 pin held low through the power-up hold is not logged
        @(negedge clk) begin ext_pin_n = 1'b0; rst_i = 1'b1; end
        repeat (3) @(negedge clk);
        rst_i = 1'b0;
        repeat (100) @(negedge clk);
        ext_pin_n = 1'b1;
        cycles_to_on(n);
        repeat (4) @(negedge clk);
        read_stat(st);
        chk("R7 pin suppressed during power-up", st, 8'h01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule